// File: doc/BRIEF.md
# Beam-Gated Video Memory Access Filter

This block sits between the processor's video memory port and a byte-wide video memory of 128 KiB. Each request is either a byte write or a 16-bit read. The read is built from two byte fetches, at the request address and at the address that follows it. The filter uses the vertical and horizontal beam counters, the number of the last visible line and a forced-blank flag to decide whether the access reaches memory.

Writes made during the active picture are dropped. Reads made during the active picture return zero. A few narrow beam positions are exceptions, and one of them writes the current open-bus byte in place of the processor data. Outside the picture, or while the display is blanked, every access passes through unchanged.

The memory itself is outside the block. The block drives two combinational read addresses and samples the two bytes that come back. It also drives a registered write strobe together with its address and data. The decision for each request is registered at the clock edge that accepts it. One cycle later the filter raises an acknowledge, and a read result is valid in that same cycle.

Top module: `vram_beam_gate`

## Requirements
- R1: The high read byte is fetched at (addr + 1) modulo 2^17, so a read at 0x1FFFF takes its high byte from address 0x00000.
- R2: While blank is 1, every read returns memory data and every write is committed with the request data, whatever the beam position.
- R3: With blank 0 on line 0, a write at hpos 0 to 4 inclusive is committed with the request data.
- R4: With blank 0 on line 0, a write at hpos 6 commits the open_bus byte in place of the request data.
- R5: With blank 0 on line 0, a write at any hpos other than 0..4 and 6 leaves memory unchanged.
- R6: With blank 0 on line last_line-1, a read returns memory data only at hpos 1362. At any other hpos on that line it returns 0x0000.
- R7: With blank 0 and vpos below last_line, any other access is void: writes leave memory unchanged and reads return 0x0000. This includes reads on line 0.
- R8: With vpos at or above last_line, reads return memory data and writes are committed.
- R9: ack is high for exactly one cycle, in the cycle after each request. Read data is valid in that cycle, and mem_we can be high only in that cycle.
- R10: The low byte of rdata is the byte at addr and the high byte is the byte at addr+1.
- R11: After reset, ack, mem_we and rdata are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = byte write, 0 = 16-bit read |
| addr | input | 17 | Byte address |
| wdata | input | 8 | Write byte |
| open_bus | input | 8 | Current open-bus byte |
| vpos | input | 9 | Vertical beam line |
| hpos | input | 11 | Horizontal beam position |
| last_line | input | 9 | Number of the last visible line |
| blank | input | 1 | Forced blank, display disabled |
| mem_rd_addr_lo | output | 17 | Read address of the low byte |
| mem_rd_addr_hi | output | 17 | Read address of the high byte |
| mem_rd_lo | input | 8 | Byte returned at mem_rd_addr_lo |
| mem_rd_hi | input | 8 | Byte returned at mem_rd_addr_hi |
| mem_we | output | 1 | Memory write strobe |
| mem_wr_addr | output | 17 | Memory write address |
| mem_wdata | output | 8 | Memory write byte |
| ack | output | 1 | Request completed |
| rdata | output | 16 | Read result |

## Verification
The bench builds the block with its default parameters: a 17-bit address, a 9-bit line counter, an 11-bit dot counter, the open-bus write at dot 6 and the read window at dot 1362. With these values the real wrap at 0x1FFFF is within reach, and so is the read window at the far end of a line. The bench sets last_line to 225. It then steps through the dots on either side of each window (4, 5, 6 and 7 on line 0, and 1361 and 1362 on line 224), and also tests a line in the middle of the picture and a line past the picture. Each write is checked by reading memory back during forced blank.

// File: rtl/vbg_pkg.sv
package vbg_pkg;
   typedef enum logic [1:0] {
      VBG_PASS    = 2'd0,
      VBG_DROP    = 2'd1,
      VBG_OPENBUS = 2'd2
   } vbg_verdict_e;
endpackage

// File: rtl/vbg_window_classify.sv
module vbg_window_classify
   import vbg_pkg::*;
#(
   parameter int VPOS_W     = 9,
   parameter int HPOS_W     = 11,
   parameter int HEAD_LIMIT = 4,
   parameter int OPENBUS_H  = 6,
   parameter int READ_HOT_H = 1362
) (
   input  logic              is_write,
   input  logic              blank,
   input  logic [VPOS_W-1:0] vpos,
   input  logic [HPOS_W-1:0] hpos,
   input  logic [VPOS_W-1:0] last_line,
   output vbg_verdict_e      verdict
);
   localparam logic [HPOS_W-1:0] HEAD_H = HPOS_W'(HEAD_LIMIT);
   localparam logic [HPOS_W-1:0] OB_H   = HPOS_W'(OPENBUS_H);
   localparam logic [HPOS_W-1:0] HOT_H  = HPOS_W'(READ_HOT_H);

   logic in_picture;
   logic on_top_line;
   logic on_pre_last;

   assign in_picture  = vpos < last_line;
   assign on_top_line = vpos == '0;
   assign on_pre_last = (last_line != '0) && (vpos == last_line - 1'b1);

   always_comb begin
      verdict = VBG_DROP;
      if (blank || !in_picture) begin
         verdict = VBG_PASS;
      end else if (is_write) begin
         if (on_top_line) begin
            if (hpos <= HEAD_H)     verdict = VBG_PASS;
            else if (hpos == OB_H)  verdict = VBG_OPENBUS;
         end
      end else begin
         if (on_pre_last && hpos == HOT_H) verdict = VBG_PASS;
      end
   end
endmodule

// File: rtl/vbg_addr_pair.sv
module vbg_addr_pair #(
   parameter int ADDR_W = 17
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] addr_lo,
   output logic [ADDR_W-1:0] addr_hi
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

   assign addr_lo = addr;
   assign addr_hi = addr + STEP;
endmodule

// File: rtl/vbg_resp_reg.sv
module vbg_resp_reg
   import vbg_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req,
   input  logic                  is_write,
   input  vbg_verdict_e          verdict,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [DATA_W-1:0]     open_bus,
   input  logic [DATA_W-1:0]     rd_lo,
   input  logic [DATA_W-1:0]     rd_hi,
   output logic                  ack,
   output logic [2*DATA_W-1:0]   rdata,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_wr_addr,
   output logic [DATA_W-1:0]     mem_wdata
);
   localparam int LANES = 2;

   logic [DATA_W-1:0] lane_in [LANES];
   logic              rd_take;
   logic              rd_open;

   assign lane_in[0] = rd_lo;
   assign lane_in[1] = rd_hi;
   assign rd_take    = req && !is_write;
   assign rd_open    = verdict == VBG_PASS;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       rdata[g*DATA_W +: DATA_W] <= '0;
         else if (rd_take) rdata[g*DATA_W +: DATA_W] <= rd_open ? lane_in[g] : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack         <= 1'b0;
         mem_we      <= 1'b0;
         mem_wr_addr <= '0;
         mem_wdata   <= '0;
      end else begin
         ack    <= req;
         mem_we <= req && is_write && (verdict != VBG_DROP);
         if (req && is_write) begin
            mem_wr_addr <= addr;
            mem_wdata   <= (verdict == VBG_OPENBUS) ? open_bus : wdata;
         end
      end
   end
endmodule

// File: rtl/vram_beam_gate.sv
module vram_beam_gate
   import vbg_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 8,
   parameter int VPOS_W     = 9,
   parameter int HPOS_W     = 11,
   parameter int HEAD_LIMIT = 4,
   parameter int OPENBUS_H  = 6,
   parameter int READ_HOT_H = 1362
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W-1:0]   open_bus,
   input  logic [VPOS_W-1:0]   vpos,
   input  logic [HPOS_W-1:0]   hpos,
   input  logic [VPOS_W-1:0]   last_line,
   input  logic                blank,
   output logic [ADDR_W-1:0]   mem_rd_addr_lo,
   output logic [ADDR_W-1:0]   mem_rd_addr_hi,
   input  logic [DATA_W-1:0]   mem_rd_lo,
   input  logic [DATA_W-1:0]   mem_rd_hi,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_wr_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   output logic                ack,
   output logic [2*DATA_W-1:0] rdata
);
   localparam int HPOS_SPAN = 1 << HPOS_W;

   initial begin
      assert (ADDR_W >= 1) else $error("ADDR_W must be at least 1");
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
      assert (READ_HOT_H < HPOS_SPAN) else $error("READ_HOT_H does not fit in HPOS_W");
      assert (OPENBUS_H < HPOS_SPAN && OPENBUS_H > HEAD_LIMIT)
         else $error("OPENBUS_H must fit in HPOS_W and lie above HEAD_LIMIT");
   end

   vbg_verdict_e verdict;
   logic [ADDR_W-1:0] pair_lo;
   logic [ADDR_W-1:0] pair_hi;

   vbg_window_classify #(
      .VPOS_W(VPOS_W), .HPOS_W(HPOS_W), .HEAD_LIMIT(HEAD_LIMIT),
      .OPENBUS_H(OPENBUS_H), .READ_HOT_H(READ_HOT_H)
   ) u_classify (
      .is_write(we), .blank(blank), .vpos(vpos), .hpos(hpos),
      .last_line(last_line), .verdict(verdict)
   );

   vbg_addr_pair #(.ADDR_W(ADDR_W)) u_pair (
      .addr(addr), .addr_lo(pair_lo), .addr_hi(pair_hi)
   );

   assign mem_rd_addr_lo = pair_lo;
   assign mem_rd_addr_hi = pair_hi;

   vbg_resp_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resp (
      .clk(clk), .rst_n(rst_n), .req(req), .is_write(we), .verdict(verdict),
      .addr(addr), .wdata(wdata), .open_bus(open_bus),
      .rd_lo(mem_rd_lo), .rd_hi(mem_rd_hi),
      .ack(ack), .rdata(rdata), .mem_we(mem_we),
      .mem_wr_addr(mem_wr_addr), .mem_wdata(mem_wdata)
   );
endmodule

// File: rtl/vram_beam_gate_chk.sv
module vram_beam_gate_chk #(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 8,
   parameter int VPOS_W     = 9,
   parameter int HPOS_W     = 11,
   parameter int OPENBUS_H  = 6,
   parameter int READ_HOT_H = 1362
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req,
   input logic                we,
   input logic [ADDR_W-1:0]   addr,
   input logic [DATA_W-1:0]   wdata,
   input logic [DATA_W-1:0]   open_bus,
   input logic [VPOS_W-1:0]   vpos,
   input logic [HPOS_W-1:0]   hpos,
   input logic [VPOS_W-1:0]   last_line,
   input logic                blank,
   input logic                mem_we,
   input logic [ADDR_W-1:0]   mem_wr_addr,
   input logic [DATA_W-1:0]   mem_wdata,
   input logic                ack,
   input logic [2*DATA_W-1:0] rdata
);
   a_r9_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> ack);

   a_r9_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !ack);

   a_r9_write_only_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ack);

   a_r7_body_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && !blank && vpos != '0 && vpos < last_line) |=> !mem_we);

   a_r2_blank_write_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && blank) |=>
         (mem_we && mem_wdata == $past(wdata) && mem_wr_addr == $past(addr)));

   a_r4_openbus_stored: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && !blank && vpos == '0 && last_line != '0 &&
       hpos == HPOS_W'(OPENBUS_H)) |=> (mem_we && mem_wdata == $past(open_bus)));

   a_r6_preline_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !we && !blank && last_line != '0 && vpos == last_line - 1'b1 &&
       hpos != HPOS_W'(READ_HOT_H)) |=> (rdata == '0));
endmodule

bind vram_beam_gate vram_beam_gate_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VPOS_W(VPOS_W), .HPOS_W(HPOS_W),
   .OPENBUS_H(OPENBUS_H), .READ_HOT_H(READ_HOT_H)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
   .open_bus(open_bus), .vpos(vpos), .hpos(hpos), .last_line(last_line),
   .blank(blank), .mem_we(mem_we), .mem_wr_addr(mem_wr_addr),
   .mem_wdata(mem_wdata), .ack(ack), .rdata(rdata)
);

// File: tb/vram_beam_gate_tb_top.sv
`timescale 1ns/1ps
module vram_beam_gate_tb_top;
   localparam int AW = 17;
   localparam int MEM_N = 1 << AW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic [16:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  open_bus = '0;
   logic [8:0]  vpos = '0;
   logic [10:0] hpos = '0;
   logic [8:0]  last_line = 9'd225;
   logic        blank = 1'b0;
   logic [16:0] mem_rd_addr_lo, mem_rd_addr_hi, mem_wr_addr;
   logic [7:0]  mem_rd_lo, mem_rd_hi, mem_wdata;
   logic        mem_we, ack;
   logic [15:0] rdata;

   logic [7:0] vmem [MEM_N];
   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   always_ff @(posedge clk) if (mem_we) vmem[mem_wr_addr] <= mem_wdata;
   assign mem_rd_lo = vmem[mem_rd_addr_lo];
   assign mem_rd_hi = vmem[mem_rd_addr_hi];

   vram_beam_gate dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
      .open_bus(open_bus), .vpos(vpos), .hpos(hpos), .last_line(last_line),
      .blank(blank), .mem_rd_addr_lo(mem_rd_addr_lo),
      .mem_rd_addr_hi(mem_rd_addr_hi), .mem_rd_lo(mem_rd_lo),
      .mem_rd_hi(mem_rd_hi), .mem_we(mem_we), .mem_wr_addr(mem_wr_addr),
      .mem_wdata(mem_wdata), .ack(ack), .rdata(rdata)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // one byte write; returns after memory would have been updated
   task automatic do_write(input logic [16:0] a, input logic [7:0] d,
                           input logic [8:0] v, input logic [10:0] h,
                           input logic bl, input logic [7:0] ob);
      @(negedge clk);
      req = 1; we = 1; addr = a; wdata = d; vpos = v; hpos = h; blank = bl; open_bus = ob;
      @(negedge clk);
      req = 0; we = 0;
      check(ack === 1'b1, "R9 write ack", ack, 1);
      @(negedge clk);
      check(ack === 1'b0, "R9 ack single pulse", ack, 0);
   endtask

   task automatic do_read(input logic [16:0] a, input logic [8:0] v,
                          input logic [10:0] h, input logic bl,
                          output logic [15:0] r);
      @(negedge clk);
      req = 1; we = 0; addr = a; vpos = v; hpos = h; blank = bl;
      @(negedge clk);
      req = 0;
      check(ack === 1'b1, "R9 read ack", ack, 1);
      check(mem_we === 1'b0, "R9 no write strobe on read", mem_we, 0);
      r = rdata;
   endtask

   task automatic peek(input logic [16:0] a, output logic [15:0] r);
      do_read(a, 9'd100, 11'd50, 1'b1, r);
   endtask

   task automatic t_reset;
      check(ack === 1'b0, "R11 ack", ack, 0);
      check(mem_we === 1'b0, "R11 mem_we", mem_we, 0);
      check(rdata === 16'h0, "R11 rdata", rdata, 0);
   endtask

   task automatic t_blank;
      logic [15:0] r;
      do_write(17'h00100, 8'h11, 9'd100, 11'd300, 1'b1, 8'hEE);
      do_write(17'h00101, 8'h22, 9'd0, 11'd9, 1'b1, 8'hEE);
      peek(17'h00100, r);
      check(r == 16'h2211, "R2 R10 blank writes then byte order", r, 16'h2211);
      do_read(17'h00100, 9'd224, 11'd5, 1'b1, r);
      check(r == 16'h2211, "R2 blank read in picture", r, 16'h2211);
   endtask

   task automatic t_line0;
      logic [15:0] r;
      for (int k = 0; k < 8; k++) do_write(17'h00200 + 17'(k), 8'hA0, 9'd0, 11'd200, 1'b1, 8'h00);
      do_write(17'h00200, 8'h30, 9'd0, 11'd0, 1'b0, 8'h5A);
      do_write(17'h00201, 8'h34, 9'd0, 11'd4, 1'b0, 8'h5A);
      do_write(17'h00202, 8'h35, 9'd0, 11'd5, 1'b0, 8'h5A);
      do_write(17'h00203, 8'h36, 9'd0, 11'd6, 1'b0, 8'h5A);
      do_write(17'h00204, 8'h37, 9'd0, 11'd7, 1'b0, 8'h5A);
      do_write(17'h00205, 8'h38, 9'd0, 11'd100, 1'b0, 8'h5A);
      peek(17'h00200, r);
      check(r == 16'h3430, "R3 line0 hpos 0 and 4 commit", r, 16'h3430);
      peek(17'h00202, r);
      check(r[7:0] == 8'hA0, "R5 line0 hpos 5 dropped", r[7:0], 8'hA0);
      check(r[15:8] == 8'h5A, "R4 line0 hpos 6 stores open bus", r[15:8], 8'h5A);
      peek(17'h00204, r);
      check(r == 16'hA0A0, "R5 line0 hpos 7 and 100 dropped", r, 16'hA0A0);
      do_read(17'h00200, 9'd0, 11'd2, 1'b0, r);
      check(r == 16'h0, "R7 line0 read is void", r, 0);
   endtask

   task automatic t_preline;
      logic [15:0] r;
      do_write(17'h00300, 8'hC3, 9'd250, 11'd0, 1'b1, 8'h00);
      do_write(17'h00301, 8'h3C, 9'd250, 11'd0, 1'b1, 8'h00);
      do_read(17'h00300, 9'd224, 11'd1362, 1'b0, r);
      check(r == 16'h3CC3, "R6 read at hot dot", r, 16'h3CC3);
      do_read(17'h00300, 9'd224, 11'd1361, 1'b0, r);
      check(r == 16'h0, "R6 read one dot early", r, 0);
      do_read(17'h00300, 9'd224, 11'd1363, 1'b0, r);
      check(r == 16'h0, "R6 read one dot late", r, 0);
      do_write(17'h00300, 8'h99, 9'd224, 11'd1362, 1'b0, 8'h00);
      peek(17'h00300, r);
      check(r[7:0] == 8'hC3, "R7 write on pre-last line dropped", r[7:0], 8'hC3);
   endtask

   task automatic t_body_and_outside;
      logic [15:0] r;
      do_write(17'h00400, 8'h41, 9'd0, 11'd0, 1'b1, 8'h00);
      do_write(17'h00401, 8'h42, 9'd0, 11'd0, 1'b1, 8'h00);
      do_write(17'h00400, 8'hFF, 9'd100, 11'd3, 1'b0, 8'h77);
      do_read(17'h00400, 9'd100, 11'd1362, 1'b0, r);
      check(r == 16'h0, "R7 mid-picture read void", r, 0);
      peek(17'h00400, r);
      check(r == 16'h4241, "R7 mid-picture write dropped", r, 16'h4241);
      do_write(17'h00401, 8'h55, 9'd225, 11'd500, 1'b0, 8'h00);
      do_read(17'h00400, 9'd225, 11'd500, 1'b0, r);
      check(r == 16'h5541, "R8 first line past picture passes", r, 16'h5541);
      do_read(17'h00400, 9'd300, 11'd7, 1'b0, r);
      check(r == 16'h5541, "R8 late line read passes", r, 16'h5541);
   endtask

   task automatic t_wrap;
      logic [15:0] r;
      do_write(17'h1FFFF, 8'h7E, 9'd0, 11'd0, 1'b1, 8'h00);
      do_write(17'h00000, 8'h81, 9'd0, 11'd0, 1'b1, 8'h00);
      peek(17'h1FFFF, r);
      check(r == 16'h817E, "R1 read wraps at top of space", r, 16'h817E);
   endtask

   initial begin
      for (int i = 0; i < MEM_N; i++) vmem[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_blank;
      t_line0;
      t_preline;
      t_body_and_outside;
      t_wrap;
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule